// File: doc/BRIEF.md
# Five-Channel Prescaled Countdown Timer Bank

This block holds five independent 24-bit down-counters behind a simple synchronous register bus. Each channel has a control word, a programmable start value and a read-only live count. A channel divides the block clock by an 8-bit prescaler and counts down from its start value. When the count runs out, the channel raises a flag in a shared status register. In one-shot mode the channel then stops. In periodic mode it reloads and keeps going.

Each channel drives its own interrupt line, which is its status flag gated by its interrupt-enable bit. Software can do three things to a running channel: pause and resume it, change its divide ratio, or force it back to idle through a counter-reset bit. The last word in the shared register space is a watchdog-control placeholder that only returns its reset value.

Register reads are combinational from the address. Writes take effect at the clock edge on which the write enable is high.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every control register reads 0x0000_0005, every start-value and live-count register reads 0, the status register (0x18) reads 0, and the watchdog placeholder (0x1C) reads 0x0000_0400.
- R2: Channel n has its control register at offset 0x20*(n/2) + 4*(n%2), so the five channels sit at 0x00, 0x04, 0x20, 0x24 and 0x40. The start value is at control+0x08 and the live count at control+0x10. Only the low 24 bits of a start-value write are kept.
- R3: Control bit layout: bit 30 enable, bit 29 interrupt enable, bit 27 mode (0 one-shot, 1 periodic), bit 26 counter reset (write-only, reads 0), bit 25 active (read-only), bits 7:0 prescaler P. The live count decrements once every P+1 clocks. Setting enable from an idle state loads the live count from the start value N and sets active. Expiry happens exactly N*(P+1) clocks after the enabling write edge.
- R4: At a one-shot expiry the channel clears enable and active, reloads the live count to N and sets its status flag. No further expiry follows.
- R5: In periodic mode the channel reloads N at every expiry and keeps counting, setting its status flag every N*(P+1) clocks.
- R6: A control write with counter reset set leaves enable and active cleared and the live count at 0, and raises no flag, even when enable is also written as 1.
- R7: Enabling with a zero start value expires at that write edge: the flag sets at once and enable is cleared.
- R8: Writing enable as 0 freezes the live count. Writing it as 1 again resumes from the frozen value, and expiry follows after the remaining count times (P+1) clocks from the resuming write.
- R9: Any control write restarts the prescaler phase and leaves the live count unchanged. A prescaler rewrite while running therefore counts the remaining value with the new divide ratio from that write.
- R10: The status register at 0x18 holds bit n for channel n and is write-one-to-clear. An expiry in the same cycle as a clear leaves the flag set.
- R11: Interrupt line n equals status bit n ANDed with channel n's interrupt enable.
- R12: Unmapped offsets read 0, writes to the watchdog placeholder and live-count registers are ignored, and each channel's activity touches no other channel's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the count reference |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, acts at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tmr_irq | output | 5 | Per-channel interrupt, flag AND interrupt enable |

## Verification
A wrong prescaler phase or count register shows up at the ports as an expiry flag that arrives one or more clocks early or late. The bench measures this to the exact clock against N*(P+1). A lost armed or frozen state becomes a wrong live count on the very next read after a pause, resume or prescaler write. A bad flag-update priority shows in the status read one clock after a coincident clear and expiry. Each interrupt line is compared with the flag and enable on every expiry and clear, so a gating error is seen within one clock.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, control bit positions and register offsets
// for the timer bank. Assumes an 8-bit byte-offset bus with 32-bit data.
package tmr_pkg;
    localparam int NUM_TMR = 5;
    localparam int CNT_W   = 24;
    localparam int PS_W    = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;

    localparam int B_EN   = 30;
    localparam int B_IE   = 29;
    localparam int B_MODE = 27;
    localparam int B_CRST = 26;
    localparam int B_ACT  = 25;

    localparam logic [PS_W-1:0]   PS_RST     = PS_W'(5);
    localparam logic [ADDR_W-1:0] OFF_STAT   = ADDR_W'(8'h18);
    localparam logic [ADDR_W-1:0] OFF_WDOG   = ADDR_W'(8'h1C);
    localparam logic [ADDR_W-1:0] DELTA_INIT = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] DELTA_LIVE = ADDR_W'(8'h10);
    localparam logic [DATA_W-1:0] WDOG_RST   = DATA_W'(32'h0000_0400);

    typedef enum logic {MODE_ONCE = 1'b0, MODE_REPEAT = 1'b1} tmr_mode_e;

    // Control offset of channel i: pairs of channels per 0x20 window.
    function automatic logic [ADDR_W-1:0] ctrl_off(input int i);
        return ADDR_W'((i / 2) * 32 + (i % 2) * 4);
    endfunction
endpackage

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
// Module: one countdown channel. Holds control fields, start value, live
// count and prescaler phase. Emits a one-cycle expire pulse at the edge on
// which the count runs out. Assumes a control write is never combined with
// a counting step: the write takes that cycle and restarts the phase.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PS_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic          init_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_rd,
    output logic [CW-1:0] init_q,
    output logic [CW-1:0] live_q,
    output logic          irq_en,
    output logic          expire
);
    logic            en_q, ie_q, armed_q;
    tmr_mode_e       mode_q;
    logic [PW-1:0]   ps_q, phase_q;
    logic            tick, last_step, start, zero_fire;
    logic [CW-1:0]   load_val;
    logic            unused_wbits;

    assign unused_wbits = ^{wdata[DW-1], wdata[28], wdata[B_ACT], wdata[24]};

    // Decode this cycle's counting step and enable-start conditions.
    always_comb begin
        tick      = en_q && (phase_q >= ps_q);
        last_step = tick && (live_q <= CW'(1));
        start     = ctrl_we && !wdata[B_CRST] && wdata[B_EN] && !en_q;
        load_val  = armed_q ? live_q : init_q;
        zero_fire = start && (load_val == '0);
        expire    = (!ctrl_we && last_step) || zero_fire;
    end

    // Channel state: control writes take priority over the counting step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            ie_q    <= 1'b0;
            armed_q <= 1'b0;
            mode_q  <= MODE_ONCE;
            ps_q    <= PS_RST;
            phase_q <= '0;
            init_q  <= '0;
            live_q  <= '0;
        end else begin
            if (init_we) init_q <= wdata[CW-1:0];
            if (ctrl_we) begin
                ie_q    <= wdata[B_IE];
                mode_q  <= tmr_mode_e'(wdata[B_MODE]);
                ps_q    <= wdata[PW-1:0];
                phase_q <= '0;
                if (wdata[B_CRST]) begin
                    en_q    <= 1'b0;
                    armed_q <= 1'b0;
                    live_q  <= '0;
                end else if (start) begin
                    if (zero_fire) begin
                        en_q    <= 1'b0;
                        armed_q <= 1'b0;
                        live_q  <= init_q;
                    end else begin
                        en_q    <= 1'b1;
                        armed_q <= 1'b1;
                        live_q  <= load_val;
                    end
                end else if (!wdata[B_EN]) begin
                    en_q <= 1'b0;
                end
            end else if (tick) begin
                phase_q <= '0;
                if (last_step) begin
                    live_q <= init_q;
                    if (mode_q == MODE_ONCE) begin
                        en_q    <= 1'b0;
                        armed_q <= 1'b0;
                    end
                end else begin
                    live_q <= live_q - CW'(1);
                end
            end else if (en_q) begin
                phase_q <= phase_q + PW'(1);
            end
        end
    end

    // Assemble the control readback word.
    always_comb begin
        ctrl_rd         = '0;
        ctrl_rd[B_EN]   = en_q;
        ctrl_rd[B_IE]   = ie_q;
        ctrl_rd[B_MODE] = mode_q;
        ctrl_rd[B_ACT]  = en_q && armed_q;
        ctrl_rd[PW-1:0] = ps_q;
    end
    assign irq_en = ie_q;

    // R6: counter reset wins over enable and clears the count
    p_crst_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && wdata[B_CRST] |=> !en_q && live_q == '0);
    // R8: a stopped channel never changes its count without a write
    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q && !ctrl_we |=> $stable(live_q));
    // R4: one-shot expiry drops enable
    p_once_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !ctrl_we && mode_q == MODE_ONCE |=> !en_q);
    // R9: a control write that keeps the channel running leaves the count
    p_keep_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && en_q && wdata[B_EN] && !wdata[B_CRST] |=> $stable(live_q));
endmodule

// File: rtl/tmr_status.sv
`timescale 1ns/1ps
// Module: shared write-one-to-clear expiry flags and interrupt gating.
// Assumes set pulses last one cycle; a set beats a clear in the same cycle.
module tmr_status #(
    parameter int N = tmr_pkg::NUM_TMR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flags,
    output logic [N-1:0] irq
);
    logic [N-1:0] clr_mask;

    assign clr_mask = clr_we ? clr_bits : '0;

    // Flag register: clear selected bits, then merge new expiries.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | set;
    end

    // Interrupt per channel: flag gated by its enable.
    assign irq = flags & ie;

    // R10: an expiry always leaves its flag set
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        |set |=> ((flags & $past(set)) == $past(set)));
    // R10: cleared bits without a new expiry read 0
    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((flags & $past(clr_bits & ~set)) == '0));
    // R10: without a clear, flags never drop
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/tmr_bank.sv
`timescale 1ns/1ps
// Module: top of the timer bank. Decodes the register bus, instantiates
// the channels and the shared status, and muxes read data. Assumes reads
// are combinational and writes act at the clock edge with bus_we high.
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NT = NUM_TMR,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [NT-1:0] tmr_irq
);
    logic [DW-1:0] ctrl_rd [NT];
    logic [CW-1:0] init_v  [NT];
    logic [CW-1:0] live_v  [NT];
    logic [NT-1:0] ie_v, exp_v, flags;
    logic          stat_we;

    assign stat_we = bus_we && (bus_addr == OFF_STAT);

    for (genvar g = 0; g < NT; g++) begin : g_ch
        localparam logic [AW-1:0] CTRL_A = AW'(ctrl_off(g));
        logic ctrl_we, init_we;
        assign ctrl_we = bus_we && (bus_addr == CTRL_A);
        assign init_we = bus_we && (bus_addr == CTRL_A + AW'(DELTA_INIT));

        tmr_channel #(.CW(CW), .DW(DW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we),
            .init_we (init_we),
            .wdata   (bus_wdata),
            .ctrl_rd (ctrl_rd[g]),
            .init_q  (init_v[g]),
            .live_q  (live_v[g]),
            .irq_en  (ie_v[g]),
            .expire  (exp_v[g])
        );
    end

    tmr_status #(.N(NT)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (exp_v),
        .clr_we   (stat_we),
        .clr_bits (bus_wdata[NT-1:0]),
        .ie       (ie_v),
        .flags    (flags),
        .irq      (tmr_irq)
    );

    // Read mux: shared words first, then per-channel registers.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_STAT) bus_rdata = DW'(flags);
        if (bus_addr == OFF_WDOG) bus_rdata = WDOG_RST;
        for (int i = 0; i < NT; i++) begin
            if (bus_addr == AW'(ctrl_off(i)))               bus_rdata = ctrl_rd[i];
            if (bus_addr == AW'(ctrl_off(i)) + DELTA_INIT)  bus_rdata = DW'(init_v[i]);
            if (bus_addr == AW'(ctrl_off(i)) + DELTA_LIVE)  bus_rdata = DW'(live_v[i]);
        end
    end

    // R11: an interrupt is only raised on a flagged channel
    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_irq & ~flags) == '0);
endmodule

// File: tb/tmr_bank_bench.sv
`timescale 1ns/1ps
module tmr_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tmr_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    tmr_bank u_tmr_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq)
    );

    always #4 clk = ~clk;

    localparam logic [31:0] EN = 32'h4000_0000, IE = 32'h2000_0000,
                            PER = 32'h0800_0000, CRST = 32'h0400_0000,
                            ACT = 32'h0200_0000;

    function automatic logic [7:0] ctrl_a(input int ch);
        return 8'((ch / 2) * 32 + (ch % 2) * 4);
    endfunction
    function automatic int exp_cycles(input int n, input int ps);
        return n * (ps + 1);
    endfunction
    function automatic logic [31:0] ctrl_val(input bit en, input bit ie, input bit per, input int ps);
        return (en ? (EN | ACT) : 32'h0) | (ie ? IE : 32'h0) | (per ? PER : 32'h0) | 32'(ps);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Write: drive now, act at next rising edge, release 1 ns after it.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #0.1; d = bus_rdata;
    endtask
    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask
    // Count edges from now until channel ch's flag is seen.
    task automatic wait_flag(input int ch, input int limit, output int k);
        logic [31:0] s;
        k = 0;
        rd(8'h18, s);
        while (!s[ch] && k < limit) begin
            cyc(1); k++; rd(8'h18, s);
        end
    endtask
    task automatic idle_all();
        for (int c = 0; c < 5; c++) wr(ctrl_a(c), CRST | 32'd5);
        wr(8'h18, 32'h1F);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int k;
        void'($urandom(32'd2024));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset values
        for (int c = 0; c < 5; c++) begin
            rd(ctrl_a(c), v);        chk("R1", "ctrl reset", v, 32'h5);
            rd(ctrl_a(c) + 8'h08, v); chk("R1", "init reset", v, 0);
            rd(ctrl_a(c) + 8'h10, v); chk("R1", "live reset", v, 0);
            cyc(1);
        end
        rd(8'h18, v); chk("R1", "status reset", v, 0);
        rd(8'h1C, v); chk("R1", "wdog reset", v, 32'h400);

        // R2 address map and 24-bit start value
        for (int c = 0; c < 5; c++) wr(ctrl_a(c) + 8'h08, 32'(c * 7 + 3));
        for (int c = 0; c < 5; c++) begin
            rd(ctrl_a(c) + 8'h08, v); chk("R2", "init map", v, 32'(c * 7 + 3));
        end
        wr(ctrl_a(4) + 8'h08, 32'hFFFF_FFFF);
        rd(ctrl_a(4) + 8'h08, v); chk("R2", "init width", v, 32'h00FF_FFFF);

        // R12 ignored writes and unmapped reads
        wr(8'h1C, 32'h0); rd(8'h1C, v); chk("R12", "wdog write ignored", v, 32'h400);
        wr(ctrl_a(1) + 8'h10, 32'h55); rd(ctrl_a(1) + 8'h10, v); chk("R12", "live write ignored", v, 0);
        rd(8'h44, v); chk("R12", "unmapped 0x44", v, 0);
        rd(8'h60, v); chk("R12", "unmapped 0x60", v, 0);

        // R6 counter reset overrides enable
        idle_all();
        wr(ctrl_a(2) + 8'h08, 32'd9);
        wr(ctrl_a(2), EN | CRST | 32'd5);
        rd(ctrl_a(2), v); chk("R6", "ctrl after crst+en", v, 32'h5);
        rd(ctrl_a(2) + 8'h10, v); chk("R6", "live after crst", v, 0);
        rd(8'h18, v); chk("R6", "no flag", v, 0);

        // R7 zero start value fires at once
        idle_all();
        wr(ctrl_a(3) + 8'h08, 32'd0);
        wr(ctrl_a(3), EN | 32'd5);
        rd(8'h18, v); chk("R7", "flag at enable", v, 32'h8);
        rd(ctrl_a(3), v); chk("R7", "enable dropped", v, 32'h5);
        wr(ctrl_a(3), 32'd5);
        rd(8'h18, v); chk("R7", "flag stays", v, 32'h8);
        chk("R11", "no irq without ie", 32'(tmr_irq), 0);

        // R3/R4/R11/R12 random one-shot runs
        for (int it = 0; it < 12; it++) begin
            int ch, ps, n; bit ie;
            ch = int'($urandom % 5); ps = int'($urandom % 8);
            n = 1 + int'($urandom % 40); ie = 1'($urandom % 2);
            idle_all();
            wr(ctrl_a(ch) + 8'h08, 32'(n));
            wr(ctrl_a(ch), (ie ? IE : 0) | EN | 32'(ps));
            rd(ctrl_a(ch), v); chk("R3", "ctrl running", v, ctrl_val(1, ie, 0, ps));
            rd(ctrl_a(ch) + 8'h10, v); chk("R3", "live loaded", v, 32'(n));
            wait_flag(ch, exp_cycles(n, ps) + 10, k);
            chk("R3", "expiry cycle", 32'(k), 32'(exp_cycles(n, ps)));
            rd(8'h18, v); chk("R12", "only own flag", v, 32'(1 << ch));
            rd(ctrl_a(ch), v); chk("R4", "stopped", v, ctrl_val(0, ie, 0, ps));
            rd(ctrl_a(ch) + 8'h10, v); chk("R4", "reloaded", v, 32'(n));
            chk("R11", "irq at expiry", 32'(tmr_irq), ie ? 32'(1 << ch) : 0);
            wr(8'h18, 32'(1 << ch));
            rd(8'h18, v); chk("R10", "w1c", v, 0);
            chk("R11", "irq after clear", 32'(tmr_irq), 0);
            cyc(2 * exp_cycles(n, ps) + 4);
            rd(8'h18, v); chk("R4", "no refire", v, 0);
        end

        // R3 largest prescaler
        idle_all();
        wr(ctrl_a(4) + 8'h08, 32'd3);
        wr(ctrl_a(4), EN | 32'd255);
        wait_flag(4, 800, k);
        chk("R3", "ps255 expiry", 32'(k), 32'(exp_cycles(3, 255)));

        // R8 pause and resume: N=20, P=2, pause after 8 counts
        idle_all();
        wr(ctrl_a(1) + 8'h08, 32'd20);
        wr(ctrl_a(1), IE | EN | 32'd2);
        cyc(exp_cycles(8, 2));
        wr(ctrl_a(1), IE | 32'd2);
        rd(ctrl_a(1) + 8'h10, v); chk("R8", "frozen value", v, 32'd12);
        cyc(100);
        rd(ctrl_a(1) + 8'h10, v); chk("R8", "still frozen", v, 32'd12);
        rd(8'h18, v); chk("R8", "no flag while paused", v, 0);
        wr(ctrl_a(1), IE | EN | 32'd2);
        rd(ctrl_a(1) + 8'h10, v); chk("R8", "resume keeps value", v, 32'd12);
        wait_flag(1, 100, k);
        chk("R8", "remaining time", 32'(k), 32'(exp_cycles(12, 2)));
        chk("R11", "irq after resume", 32'(tmr_irq), 32'h2);

        // R9 prescaler change: N=16, P=3 for 4 counts, then P=1
        idle_all();
        wr(ctrl_a(0) + 8'h08, 32'd16);
        wr(ctrl_a(0), EN | 32'd3);
        cyc(exp_cycles(4, 3));
        rd(ctrl_a(0) + 8'h10, v); chk("R9", "before change", v, 32'd12);
        wr(ctrl_a(0), EN | 32'd1);
        rd(ctrl_a(0) + 8'h10, v); chk("R9", "count kept", v, 32'd12);
        cyc(exp_cycles(2, 1));
        rd(ctrl_a(0) + 8'h10, v); chk("R9", "new ratio", v, 32'd10);
        wait_flag(0, 100, k);
        chk("R9", "expiry after change", 32'(k + 4), 32'(exp_cycles(12, 1)));

        // R5 periodic: N=3, P=1, period 6
        idle_all();
        wr(ctrl_a(2) + 8'h08, 32'd3);
        wr(ctrl_a(2), IE | PER | EN | 32'd1);
        wait_flag(2, 20, k);
        chk("R5", "first period", 32'(k), 32'd6);
        for (int p = 0; p < 3; p++) begin
            wr(8'h18, 32'h4);
            chk("R11", "irq cleared", 32'(tmr_irq), 0);
            wait_flag(2, 20, k);
            chk("R5", "next period", 32'(k + 1), 32'd6);
            chk("R11", "irq periodic", 32'(tmr_irq), 32'h4);
        end
        rd(ctrl_a(2), v); chk("R5", "still running", v, ctrl_val(1, 1, 1, 1));

        // R10 set wins over clear: N=1, P=1, period 2
        idle_all();
        wr(ctrl_a(3) + 8'h08, 32'd1);
        wr(ctrl_a(3), PER | EN | 32'd1);
        wait_flag(3, 10, k);
        wr(8'h18, 32'h8);
        rd(8'h18, v); chk("R10", "cleared between expiries", v, 0);
        wr(8'h18, 32'h8);
        rd(8'h18, v); chk("R10", "set beats clear", v, 32'h8);
        idle_all();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule